// File: doc/BRIEF.md
# Floating-point to 64-bit integer ceiling converter

This block takes one IEEE 754 operand, either single precision carried in the low 32 bits of a 64-bit input word or a full double, and turns it into a 64-bit two's-complement signed integer. It always rounds toward positive infinity. The conversion is one combinational pass. It unpacks the fields, aligns the significand to the binary point, applies the ceiling increment, negates and selects a default. A single register stage holds the result, so each accepted operand produces its outputs on the next clock edge.

Some operations cannot be represented: an infinity, a NaN, or a value whose ceiling lies outside the signed 64-bit range. These raise an invalid flag. Two control inputs then decide the outcome. A trap enable suppresses the write and raises an exception request. A NaN-handling mode bit selects the saturated default written when no trap is taken: either the legacy default for every invalid case, or defaults that depend on the sign and on whether the input is a NaN.

Top module: `ceil_to_i64`

## Requirements
- R1: Outputs are registered. For an operand accepted with `in_valid` high at a rising edge, all outputs reflect it after that edge. When `in_valid` was low at the edge, `out_we`, `out_invalid`, `out_inexact` and `out_trap` are 0 and `out_value` keeps its value. Reset drives every output to 0.
- R2: A finite positive operand whose ceiling fits the range gives ceil(x). A nonzero discarded fraction adds 1 to the integer part, for example +0.5 gives 1 and +1.5 gives 2.
- R3: A finite negative operand with a fraction gives its truncated magnitude, negated (-0.5 gives 0, -1.5 gives -1, -1.0 gives -1).
- R4: With `is_double`=0, the operand is the single in `operand[31:0]` (sign bit 31, 8 exponent bits 30:23, 23 fraction bits) and bits 63:32 have no effect. With `is_double`=1, it is the double in all 64 bits (sign 63, exponent 62:52, fraction 51:0).
- R5: A zero of either sign gives 0 with inexact low. A subnormal gives 1 if positive and 0 if negative, with inexact high.
- R6: `out_inexact` is high exactly when a valid conversion discards a nonzero fraction. It is never high together with `out_invalid`.
- R7: `out_invalid` is high for infinities, for NaNs (quiet or signalling), and for operands whose ceiling lies below -2^63 or above 2^63-1. -2^63 itself converts validly to 0x8000_0000_0000_0000.
- R8: With `nan2008`=0 and `trap_en`=0, every invalid operation writes 0x7FFF_FFFF_FFFF_FFFF.
- R9: With `nan2008`=1 and `trap_en`=0, an invalid operation writes 0x7FFF_FFFF_FFFF_FFFF for +infinity or positive overflow, 0x8000_0000_0000_0000 for -infinity or negative overflow, and 0 for any NaN.
- R10: With `trap_en`=1, an invalid operation gives `out_we`=0, `out_trap`=1 and `out_invalid`=1 in the result cycle, and `out_value` is unchanged.
- R11: Every accepted operation that does not trap gives `out_we`=1 in its result cycle, and `out_trap` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present this cycle |
| is_double | input | 1 | 1: double in all 64 bits; 0: single in bits 31:0 |
| nan2008 | input | 1 | 1: sign/NaN-dependent defaults; 0: legacy default |
| trap_en | input | 1 | Invalid-operation trap enable |
| operand | input | 64 | Source floating-point bits |
| out_we | output | 1 | Result write enable |
| out_value | output | 64 | Signed 64-bit integer result |
| out_invalid | output | 1 | Invalid operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_trap | output | 1 | Exception request |

## Verification
The bench sweeps every single-precision exponent and the doubles around the top of the 64-bit range. It compares each result with an arithmetic model that works on 128-bit integers. The sweeps are aimed at the cases that break easily, and each has a typical symptom:
- exponent 63: an aligner that mishandles it either rejects -2^63 or accepts +2^63;
- negative values with a fraction: a rounder that ignores the sign moves them down instead of up;
- defaults: defaults keyed on the wrong case show up as a signed saturation for a NaN, or as 2^63-1 for negative overflow in 2008 mode;
- trapping: a trap that still loads the result register shows as a changed output value;
- flags: a missing exclusion shows as inexact raised beside invalid;
- single precision: stray upper bits in a single operand show up as a changed result.

// File: rtl/ceil_pkg.sv
package ceil_pkg;

   typedef enum logic [2:0] {
      FC_ZERO,
      FC_SUB,
      FC_NORM,
      FC_INF,
      FC_NAN
   } fp_class_e;

   localparam int SP_EXP_W = 8;
   localparam int SP_MAN_W = 23;
   localparam int DP_EXP_W = 11;
   localparam int DP_MAN_W = 52;

endpackage

// File: rtl/fp_field_split.sv
module fp_field_split
   import ceil_pkg::*;
#(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   parameter int CW    = 53,
   parameter int EW    = 13
) (
   input  logic [EXP_W+MAN_W:0] bits,
   output logic                 sign,
   output logic signed [EW-1:0] exp_unb,
   output logic [CW-1:0]        sig,
   output fp_class_e            cls
);

   localparam int               BIAS     = (1 << (EXP_W - 1)) - 1;
   localparam logic [EXP_W-1:0] EXP_ONES = '1;

   if (CW < MAN_W + 1) begin : g_bad_cw
      $error("fp_field_split: CW too narrow for the fraction");
   end
   if (EW < EXP_W + 2) begin : g_bad_ew
      $error("fp_field_split: EW too narrow for the unbiased exponent");
   end

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;

   always_comb begin
      sign    = bits[EXP_W+MAN_W];
      exp_f   = bits[EXP_W+MAN_W-1:MAN_W];
      man_f   = bits[MAN_W-1:0];
      exp_unb = $signed(EW'({1'b0, exp_f})) - $signed(EW'(BIAS));
      sig     = CW'({1'b1, man_f}) << (CW - 1 - MAN_W);
      if (exp_f == '0)
         cls = (man_f == '0) ? FC_ZERO : FC_SUB;
      else if (exp_f == EXP_ONES)
         cls = (man_f == '0) ? FC_INF : FC_NAN;
      else
         cls = FC_NORM;
   end

endmodule

// File: rtl/ceil_align.sv
module ceil_align
   import ceil_pkg::*;
#(
   parameter int CW = 53,
   parameter int EW = 13,
   parameter int IW = 64
) (
   input  logic                 sign,
   input  logic signed [EW-1:0] exp_unb,
   input  logic [CW-1:0]        sig,
   input  fp_class_e            cls,
   output logic [IW-1:0]        mag,
   output logic                 frac_nz,
   output logic                 ovf
);

   localparam int FB  = CW - 1;
   localparam int TW  = CW + IW - 1;
   localparam int SHW = $clog2(IW);
   localparam logic signed [EW-1:0] E_TOP  = EW'(IW - 1);
   localparam logic [CW-1:0]        SIG_PW = CW'(1) << FB;

   if (CW > IW - 1) begin : g_bad_cw
      $error("ceil_align: significand must be narrower than the integer");
   end
   if (EW < SHW + 2) begin : g_bad_ew
      $error("ceil_align: exponent too narrow for the integer width");
   end

   logic [TW-1:0] shifted;
   logic [IW-1:0] whole;
   logic [FB-1:0] frac;

   always_comb begin
      shifted = TW'(sig) << exp_unb[SHW-1:0];
      whole   = shifted[TW-1:FB];
      frac    = shifted[FB-1:0];
      mag     = '0;
      frac_nz = 1'b0;
      ovf     = 1'b0;
      case (cls)
         FC_SUB: begin
            mag     = IW'(!sign);
            frac_nz = 1'b1;
         end
         FC_NORM: begin
            if (exp_unb < 0) begin
               mag     = IW'(!sign);
               frac_nz = 1'b1;
            end else if (exp_unb < E_TOP) begin
               frac_nz = |frac;
               mag     = whole + IW'(!sign && (|frac));
            end else if (exp_unb == E_TOP && sign && sig == SIG_PW) begin
               mag = IW'(1) << (IW - 1);
            end else begin
               ovf = 1'b1;
            end
         end
         default: begin
            mag = '0;
         end
      endcase
   end

endmodule

// File: rtl/ceil_select.sv
module ceil_select
   import ceil_pkg::*;
#(
   parameter int IW = 64
) (
   input  logic          sign,
   input  fp_class_e     cls,
   input  logic [IW-1:0] mag,
   input  logic          frac_nz,
   input  logic          ovf,
   input  logic          nan2008,
   input  logic          trap_en,
   output logic [IW-1:0] value,
   output logic          we,
   output logic          invalid,
   output logic          inexact,
   output logic          trap
);

   localparam logic [IW-1:0] POS_SAT = {1'b0, {(IW-1){1'b1}}};
   localparam logic [IW-1:0] NEG_SAT = {1'b1, {(IW-1){1'b0}}};

   if (IW < 2) begin : g_bad_iw
      $error("ceil_select: integer width too small");
   end

   logic [IW-1:0] dflt;

   always_comb begin
      invalid = (cls == FC_INF) || (cls == FC_NAN) || ovf;
      if (!nan2008)
         dflt = POS_SAT;
      else if (cls == FC_NAN)
         dflt = '0;
      else
         dflt = sign ? NEG_SAT : POS_SAT;
      value   = invalid ? dflt : (sign ? (~mag + IW'(1)) : mag);
      inexact = frac_nz && !invalid;
      trap    = invalid && trap_en;
      we      = !trap;
   end

endmodule

// File: rtl/ceil_to_i64.sv
module ceil_to_i64
   import ceil_pkg::*;
#(
   parameter int IW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          is_double,
   input  logic          nan2008,
   input  logic          trap_en,
   input  logic [63:0]   operand,
   output logic          out_we,
   output logic [IW-1:0] out_value,
   output logic          out_invalid,
   output logic          out_inexact,
   output logic          out_trap
);

   localparam int CW = DP_MAN_W + 1;
   localparam int EW = DP_EXP_W + 2;
   localparam int LANE_EXP [2] = '{SP_EXP_W, DP_EXP_W};
   localparam int LANE_MAN [2] = '{SP_MAN_W, DP_MAN_W};

   if (IW != 64) begin : g_bad_iw
      $error("ceil_to_i64: operand word and result are 64 bits");
   end

   for (genvar g = 0; g < 2; g++) begin : g_lane
      localparam int LW = LANE_EXP[g] + LANE_MAN[g] + 1;
      logic                 sign;
      logic signed [EW-1:0] exp_unb;
      logic [CW-1:0]        sig;
      fp_class_e            cls;
      fp_field_split #(
         .EXP_W (LANE_EXP[g]),
         .MAN_W (LANE_MAN[g]),
         .CW    (CW),
         .EW    (EW)
      ) u_split (
         .bits    (operand[LW-1:0]),
         .sign    (sign),
         .exp_unb (exp_unb),
         .sig     (sig),
         .cls     (cls)
      );
   end

   logic                 s_sign;
   logic signed [EW-1:0] s_exp;
   logic [CW-1:0]        s_sig;
   fp_class_e            s_cls;

   always_comb begin
      if (is_double) begin
         s_sign = g_lane[1].sign;
         s_exp  = g_lane[1].exp_unb;
         s_sig  = g_lane[1].sig;
         s_cls  = g_lane[1].cls;
      end else begin
         s_sign = g_lane[0].sign;
         s_exp  = g_lane[0].exp_unb;
         s_sig  = g_lane[0].sig;
         s_cls  = g_lane[0].cls;
      end
   end

   logic [IW-1:0] a_mag;
   logic          a_frac;
   logic          a_ovf;

   ceil_align #(.CW(CW), .EW(EW), .IW(IW)) u_align (
      .sign    (s_sign),
      .exp_unb (s_exp),
      .sig     (s_sig),
      .cls     (s_cls),
      .mag     (a_mag),
      .frac_nz (a_frac),
      .ovf     (a_ovf)
   );

   logic [IW-1:0] c_value;
   logic          c_we, c_inv, c_inx, c_trap;

   ceil_select #(.IW(IW)) u_select (
      .sign    (s_sign),
      .cls     (s_cls),
      .mag     (a_mag),
      .frac_nz (a_frac),
      .ovf     (a_ovf),
      .nan2008 (nan2008),
      .trap_en (trap_en),
      .value   (c_value),
      .we      (c_we),
      .invalid (c_inv),
      .inexact (c_inx),
      .trap    (c_trap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_we      <= 1'b0;
         out_value   <= '0;
         out_invalid <= 1'b0;
         out_inexact <= 1'b0;
         out_trap    <= 1'b0;
      end else begin
         out_we      <= in_valid && c_we;
         out_invalid <= in_valid && c_inv;
         out_inexact <= in_valid && c_inx;
         out_trap    <= in_valid && c_trap;
         if (in_valid && c_we)
            out_value <= c_value;
      end
   end

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_we && !out_trap && !out_invalid && !out_inexact));

   a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_value));

   a_r6_inexact_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_inexact && out_invalid));

   a_r8_legacy_default: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !nan2008 && !trap_en) |=>
         (!out_invalid || out_value == {1'b0, {(IW-1){1'b1}}}));

   a_r10_trap_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      out_trap |-> (!out_we && out_invalid && $stable(out_value)));

   a_r11_write: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !trap_en) |=> (out_we && !out_trap));

endmodule

// File: tb/ceil_to_i64_tb.sv
`timescale 1ns/1ps
module ceil_to_i64_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        is_double = 1'b0;
   logic        nan2008 = 1'b0;
   logic        trap_en = 1'b0;
   logic [63:0] operand = '0;
   logic        out_we, out_invalid, out_inexact, out_trap;
   logic [63:0] out_value;

   int total = 0;
   int bad = 0;
   logic [63:0] last_val = '0;

   always #2.5 clk = ~clk;

   ceil_to_i64 u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_double(is_double),
      .nan2008(nan2008), .trap_en(trap_en), .operand(operand),
      .out_we(out_we), .out_value(out_value), .out_invalid(out_invalid),
      .out_inexact(out_inexact), .out_trap(out_trap)
   );

   localparam logic [63:0] PMAX = 64'h7FFF_FFFF_FFFF_FFFF;
   localparam logic [63:0] NMIN = 64'h8000_0000_0000_0000;

   // returns {we, invalid, inexact, trap, value}
   function automatic logic [67:0] model(input logic dbl, input logic [63:0] op,
                                         input logic m2008, input logic ten);
      logic s, nan_in, special, zero, big, fr, inv;
      int ef, mw, bias, emax, e, sh;
      logic [63:0] mf;
      logic [127:0] sig, q;
      logic signed [127:0] r;
      logic [63:0] val;
      if (dbl) begin
         s = op[63]; ef = int'(op[62:52]); mf = {12'd0, op[51:0]};
         mw = 52; bias = 1023; emax = 2047;
      end else begin
         s = op[31]; ef = int'(op[30:23]); mf = {41'd0, op[22:0]};
         mw = 23; bias = 127; emax = 255;
      end
      special = (ef == emax);
      nan_in  = special && (mf != 0);
      zero    = (ef == 0) && (mf == 0);
      big = 1'b0; fr = 1'b0; q = '0;
      sig = (128'd1 << mw) | {64'd0, mf};
      if (special || zero) begin
         q = '0;
      end else if (ef == 0) begin
         fr = 1'b1;
      end else begin
         e  = ef - bias;
         sh = e - mw;
         if (sh > 64) big = 1'b1;
         else if (sh >= 0) q = sig << sh;
         else if (-sh > 60) fr = 1'b1;
         else begin
            q  = sig >> (-sh);
            fr = (sig & ((128'd1 << (-sh)) - 128'd1)) != 0;
         end
      end
      r = s ? -$signed(q) : $signed(q + {127'd0, fr});
      inv = special || big || (r > $signed({64'd0, PMAX}))
            || (r < -$signed(128'd1 << 63));
      if (inv) begin
         if (!m2008) val = PMAX;
         else if (nan_in) val = '0;
         else val = s ? NMIN : PMAX;
      end else val = r[63:0];
      return {!(inv && ten), inv, fr && !inv, inv && ten, val};
   endfunction

   task automatic run_op(input string tag, input logic dbl, input logic [63:0] op,
                         input logic m2008, input logic ten);
      logic [67:0] ex;
      logic [67:0] got;
      string t;
      ex = model(dbl, op, m2008, ten);
      if (!ex[67]) ex[63:0] = last_val;
      t = tag;
      if (t == "") begin
         if (ex[64]) t = "R10";
         else if (ex[66]) t = m2008 ? "R9" : "R8";
         else if (ex[65]) t = (ex[63] || ex[63:0] == 0) ? "R3" : "R2";
         else t = "R11";
      end
      is_double = dbl; operand = op; nan2008 = m2008; trap_en = ten; in_valid = 1'b1;
      @(negedge clk);
      got = {out_we, out_invalid, out_inexact, out_trap, out_value};
      total++;
      if (got != ex) begin
         bad++;
         $display("FAIL %s: op=%h dbl=%0b m=%0b t=%0b got we/inv/inx/trp=%b val=%h expected %b val=%h",
                  t, op, dbl, m2008, ten, got[67:64], got[63:0], ex[67:64], ex[63:0]);
      end
      if (ex[67]) last_val = ex[63:0];
   endtask

   task automatic chk_val(input string tag, input logic [63:0] want, input logic want_inx);
      total++;
      if (out_value !== want || out_inexact !== want_inx) begin
         bad++;
         $display("FAIL %s: got val=%h inx=%0b expected val=%h inx=%0b",
                  tag, out_value, out_inexact, want, want_inx);
      end
   endtask

   task automatic chk_flag(input string tag, input logic got, input logic want);
      total++;
      if (got !== want) begin
         bad++;
         $display("FAIL %s: got %0b expected %0b", tag, got, want);
      end
   endtask

   initial begin
      logic [63:0] sav;
      repeat (3) @(negedge clk);
      total++;
      if ({out_we, out_invalid, out_inexact, out_trap, out_value} !== 68'd0) begin
         bad++;
         $display("FAIL R1 reset: got %h expected 0",
                  {out_we, out_invalid, out_inexact, out_trap, out_value});
      end
      rst_n = 1'b1;
      @(negedge clk);

      // directed doubles
      run_op("R2", 1, 64'h3FE0_0000_0000_0000, 0, 0); chk_val("R2 +0.5", 64'd1, 1);
      run_op("R3", 1, 64'hBFE0_0000_0000_0000, 0, 0); chk_val("R3 -0.5", 64'd0, 1);
      run_op("R6", 1, 64'h3FF0_0000_0000_0000, 0, 0); chk_val("R6 +1.0", 64'd1, 0);
      run_op("R3", 1, 64'hBFF0_0000_0000_0000, 0, 0); chk_val("R3 -1.0", '1, 0);
      run_op("R3", 1, 64'hBFF8_0000_0000_0000, 1, 0); chk_val("R3 -1.5", '1, 1);
      run_op("R2", 1, 64'h43DF_FFFF_FFFF_FFFF, 0, 0); chk_val("R2 below 2^63", 64'h7FFF_FFFF_FFFF_FC00, 0);
      run_op("R7", 1, 64'hC3E0_0000_0000_0000, 1, 1); chk_val("R7 -2^63", NMIN, 0);
      chk_flag("R7 -2^63 valid", out_invalid, 0);
      run_op("R5", 1, 64'h8000_0000_0000_0000, 1, 0); chk_val("R5 -0", 64'd0, 0);
      run_op("R5", 1, 64'h0000_0000_0000_0001, 0, 0); chk_val("R5 +denorm", 64'd1, 1);
      run_op("R5", 1, 64'h8000_0000_0000_0001, 0, 0); chk_val("R5 -denorm", 64'd0, 1);
      for (int m = 0; m < 2; m++) begin
         for (int t = 0; t < 2; t++) begin
            run_op("R7", 1, 64'h43E0_0000_0000_0000, m[0], t[0]);
            run_op("R7", 1, 64'hC3E0_0000_0000_0001, m[0], t[0]);
            run_op("R9", 1, 64'h7FF0_0000_0000_0000, m[0], t[0]);
            run_op("R9", 1, 64'hFFF0_0000_0000_0000, m[0], t[0]);
            run_op("R9", 1, 64'h7FF8_0000_0000_0000, m[0], t[0]);
            run_op("R9", 1, 64'hFFF0_0000_0000_0001, m[0], t[0]);
         end
      end
      run_op("R9", 1, 64'hFFF0_0000_0000_0000, 1, 0); chk_val("R9 -inf 2008", NMIN, 0);
      run_op("R9", 1, 64'h7FF0_0000_0000_0001, 1, 0); chk_val("R9 sNaN 2008", 64'd0, 0);
      run_op("R8", 1, 64'hFFF0_0000_0000_0000, 0, 0); chk_val("R8 -inf legacy", PMAX, 0);
      run_op("R11", 1, 64'h4000_0000_0000_0000, 0, 1); chk_val("R11 +2.0", 64'd2, 0);
      sav = out_value;
      run_op("R10", 1, 64'h7FF8_0000_0000_0000, 1, 1);
      chk_flag("R10 trap raised", out_trap, 1);
      chk_val("R10 value held", sav, 0);

      // single precision with garbage in the upper word
      run_op("R4", 0, 64'hDEAD_BEEF_3FC0_0000, 0, 0); chk_val("R4 +1.5 single", 64'd2, 1);
      run_op("R4", 0, 64'hFFFF_FFFF_BFC0_0000, 0, 0); chk_val("R4 -1.5 single", '1, 1);
      run_op("R4", 0, 64'h1234_5678_DF00_0000, 1, 0); chk_val("R4 -2^63 single", NMIN, 0);

      // idle cycle
      sav = out_value;
      in_valid = 1'b0;
      @(negedge clk);
      chk_flag("R1 idle we", out_we, 0);
      chk_flag("R1 idle flags", out_invalid | out_inexact | out_trap, 0);
      chk_val("R1 idle hold", sav, 0);

      // exhaustive single exponent sweep
      for (int ef = 0; ef < 256; ef++)
         for (int s = 0; s < 2; s++)
            for (int k = 0; k < 4; k++)
               for (int mt = 0; mt < 4; mt++) begin
                  logic [22:0] mf;
                  case (k)
                     0: mf = '0;
                     1: mf = 23'd1;
                     2: mf = 23'h40_0000;
                     default: mf = 23'($urandom);
                  endcase
                  run_op("", 0, {32'($urandom), s[0], 8'(ef), mf}, mt[0], mt[1]);
               end

      // double exponents near the range edge plus extremes
      for (int i = 0; i < 110; i++)
         for (int s = 0; s < 2; s++)
            for (int k = 0; k < 4; k++)
               for (int mt = 0; mt < 4; mt++) begin
                  logic [10:0] ef;
                  logic [51:0] mf;
                  ef = (i < 104) ? 11'(1000 + i) : ((i < 107) ? 11'(i - 104) : 11'(2044 + i - 107));
                  case (k)
                     0: mf = '0;
                     1: mf = 52'd1;
                     2: mf = '1;
                     default: mf = {20'($urandom), 32'($urandom)};
                  endcase
                  run_op("", 1, {s[0], ef, mf}, mt[0], mt[1]);
               end

      // random
      for (int i = 0; i < 3000; i++)
         run_op("", i[0], {32'($urandom), 32'($urandom)}, i[1], i[2]);

      in_valid = 1'b0;
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R1 watchdog: got no completion expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule